// File: doc/BRIEF.md
# Cascadable Crosspoint Configuration Shifter

This block is the serial configuration front end of one four-output crosspoint tile. Tiles are wired into a grid. The tiles of the leftmost column are chained top to bottom through their column outputs. Every tile is chained to its right-hand neighbour through its row output. A host sends frames into the top-left tile. Each frame carries a row count and a column count. A tile decrements the row count when it passes a frame down the first column, and it decrements the column count when it passes a frame along a row. The tile that receives a frame with both counts at zero is the target and consumes the frame.

A write frame that reaches its target is held in a staging register. It does not affect the switch until the host raises the level-sensitive load input. On every clock edge while load is high, the staged value is copied into the active configuration register. That register drives four input-select fields and their enable bits.

A read frame that reaches its target makes the tile send a reply frame, holding its active configuration, on both of its outputs. Tiles that receive a reply pass it along the row and decrement its column field on the way. The column field that reaches the host is therefore 63 minus the number of tiles the reply passed through.

Top module: `xpt_cfg_shifter`

## Requirements
- R1: While reset is asserted and after it is released with no further activity, out_sel and out_en are all zero and row_so and col_so are low.
- R2: The line idles low. A frame is a 1 start bit followed by 30 bits, most significant first. Bit 29 is the read flag (1 = read). Bits 28:23 hold the row count and bits 22:17 the column count. Bits 16:1 hold four fields: output 0 at 16:13, down to output 3 at 4:1. Each field has a 3-bit select in its upper bits and an enable in its lowest bit. Bit 0 marks a reply frame. A write frame with both counts zero is staged, and out_sel[3i+2:3i] and out_en[i] show output i's field after the next load.
- R3: While load is low, out_sel and out_en keep their value, even when a new write frame is staged.
- R4: On each clock edge with load high, the staged value is copied to the active register. A write frame staged while load stays high appears on the outputs one edge after the edge that samples its last bit.
- R5: In a first-column tile, a non-reply frame with a nonzero row count is sent on col_so with the row count reduced by one and every other bit unchanged. Nothing is sent on row_so.
- R6: A non-reply frame with a zero row count and a nonzero column count is sent on row_so with the column count reduced by one. Nothing is sent on col_so.
- R7: A tile outside the first column discards non-reply frames with a nonzero row count, and col_so stays low.
- R8: A read frame with both counts zero produces a reply on both outputs. The reply has read flag 1, both counts at 63, the active configuration in bits 16:1 and bit 0 set. The active configuration is left unchanged.
- R9: A reply frame, whatever its counts, is sent on row_so only, with its column count reduced by one.
- R10: Frames that are forwarded, replied to or passed on leave the staged value untouched, so a later load restores the last targeted write.
- R11: A forwarded or reply frame's start bit appears on its output right after the edge that samples the incoming frame's last bit. A consumed write frame produces no start bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk | input | 1 | Serial clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sdi | input | 1 | Serial frame input |
| load | input | 1 | Level-sensitive commit of the staged value |
| row_so | output | 1 | Serial output toward the tile on the right |
| row_sclk | output | 1 | Forwarded clock for row_so |
| col_so | output | 1 | Serial output toward the tile below (first column only) |
| col_sclk | output | 1 | Forwarded clock for col_so (low outside the first column) |
| out_sel | output | 12 | Input select of each output, 3 bits per output |
| out_en | output | 4 | Enable of each output |

## Verification
Row counts are swept from 1 to 63 with varied column counts. This separates forwarding down the column from forwarding along the row, and it exposes a decrement applied to the wrong field. Column counts are then swept from 1 to 63 with a zero row count. Sixteen write patterns with distinct selects and enables check that each field lands on its own output pin. A write issued while load is held high separates a level-sensitive copy from an edge-triggered one. Read and reply frames at both kinds of tile check the reply content and that the reply path ignores the counts.

// File: rtl/xpt_cfg_shifter.sv
module xpt_cfg_shifter #(
  parameter int FRAME_W   = 30,
  parameter int AW        = 6,
  parameter int NOUT      = 4,
  parameter int SELW      = 3,
  parameter int FIRST_COL = 1
) (
  input  logic                   sclk,
  input  logic                   rst_n,
  input  logic                   sdi,
  input  logic                   load,
  output logic                   row_so,
  output logic                   row_sclk,
  output logic                   col_so,
  output logic                   col_sclk,
  output logic [NOUT*SELW-1:0]   out_sel,
  output logic [NOUT-1:0]        out_en
);
  localparam int FLDW  = SELW + 1;
  localparam int CFGW  = NOUT * FLDW;
  localparam int CW    = $clog2(FRAME_W + 1);
  localparam int TXW   = FRAME_W + 1;
  localparam int RD_B  = FRAME_W - 1;
  localparam int ROW_L = RD_B - AW;
  localparam int COL_L = ROW_L - AW;
  localparam int CFG_L = COL_L - CFGW;

  logic                rx_busy;
  logic [CW-1:0]       rx_cnt;
  logic [FRAME_W-2:0]  rx_sr;
  logic [TXW-1:0]      tx_row, tx_col;
  logic [CFGW-1:0]     staged, cfg_q;

  logic [FRAME_W-1:0]  word, row_word, col_word, reply;
  logic                frame_end, ld_row, ld_col, stage_wr;
  logic [AW-1:0]       w_row, w_col;

  assign word      = {rx_sr, sdi};
  assign frame_end = rx_busy && (rx_cnt == CW'(FRAME_W - 1));
  assign w_row     = word[ROW_L +: AW];
  assign w_col     = word[COL_L +: AW];

  always_comb begin
    reply = '0;
    reply[RD_B]            = 1'b1;
    reply[ROW_L +: AW]     = '1;
    reply[COL_L +: AW]     = '1;
    reply[CFG_L +: CFGW]   = cfg_q;
    reply[0]               = 1'b1;
    row_word               = word;
    row_word[COL_L +: AW]  = w_col - 1'b1;
    col_word               = word;
    col_word[ROW_L +: AW]  = w_row - 1'b1;
    ld_row = 1'b0; ld_col = 1'b0; stage_wr = 1'b0;
    if (frame_end) begin
      if (word[0])            ld_row = 1'b1;
      else if (w_row != '0)   ld_col = (FIRST_COL != 0);
      else if (w_col != '0)   ld_row = 1'b1;
      else if (word[RD_B]) begin
        ld_row = 1'b1; ld_col = 1'b1;
        row_word = reply; col_word = reply;
      end else                stage_wr = 1'b1;
    end
  end

  always_ff @(posedge sclk or negedge rst_n) begin
    if (!rst_n) begin
      rx_busy <= 1'b0;
      rx_cnt  <= '0;
      rx_sr   <= '0;
      tx_row  <= '0;
      tx_col  <= '0;
      staged  <= '0;
      cfg_q   <= '0;
    end else begin
      if (rx_busy) begin
        rx_sr  <= word[FRAME_W-2:0];
        rx_cnt <= frame_end ? '0 : rx_cnt + 1'b1;
        if (frame_end) rx_busy <= 1'b0;
      end else if (sdi) begin
        rx_busy <= 1'b1;
        rx_cnt  <= '0;
      end
      tx_row <= ld_row ? {1'b1, row_word} : {tx_row[TXW-2:0], 1'b0};
      tx_col <= ld_col ? {1'b1, col_word} : {tx_col[TXW-2:0], 1'b0};
      if (stage_wr) staged <= word[CFG_L +: CFGW];
      if (load)     cfg_q  <= staged;
    end
  end

  assign row_so   = tx_row[TXW-1];
  assign col_so   = tx_col[TXW-1];
  assign row_sclk = sclk;
  assign col_sclk = (FIRST_COL != 0) ? sclk : 1'b0;

  for (genvar i = 0; i < NOUT; i++) begin : g_out
    assign out_sel[i*SELW +: SELW] = cfg_q[CFGW-1-i*FLDW -: SELW];
    assign out_en[i]               = cfg_q[CFGW-FLDW*(i+1)];
  end

  p_cfg_hold_r3: assert property (@(posedge sclk) disable iff (!rst_n)
    !load |=> ($stable(out_sel) && $stable(out_en)));

  p_cfg_copy_r4: assert property (@(posedge sclk) disable iff (!rst_n)
    load |=> (cfg_q == $past(staged)));

  p_stage_at_end_r10: assert property (@(posedge sclk) disable iff (!rst_n)
    !$stable(staged) |-> $past(frame_end));

  p_rx_count_r2: assert property (@(posedge sclk) disable iff (!rst_n)
    rx_busy |-> (rx_cnt < CW'(FRAME_W)));
endmodule

// File: tb/xpt_cfg_shifter_test.sv
module frame_mon (
  input  logic        clk,
  input  logic        so,
  output logic [29:0] last,
  output int          n
);
  logic busy;
  int cnt;
  logic [29:0] sr;
  initial begin busy = 0; n = 0; last = '0; sr = '0; cnt = 0; end
  always @(negedge clk) begin
    if (!busy) begin
      if (so === 1'b1) begin busy = 1; cnt = 0; end
    end else begin
      sr = {sr[28:0], so};
      cnt++;
      if (cnt == 30) begin last = sr; n++; busy = 0; end
    end
  end
endmodule

module xpt_cfg_shifter_test;
  logic clk = 0, rst_n = 0, sdi = 0, load = 0;
  logic row_so, row_sclk, col_so, col_sclk, row_so2, row_sclk2, col_so2, col_sclk2;
  logic [11:0] out_sel, out_sel2;
  logic [3:0]  out_en, out_en2;
  logic lat_row, lat_col;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  xpt_cfg_shifter uut (.sclk(clk), .rst_n(rst_n), .sdi(sdi), .load(load),
    .row_so(row_so), .row_sclk(row_sclk), .col_so(col_so), .col_sclk(col_sclk),
    .out_sel(out_sel), .out_en(out_en));
  xpt_cfg_shifter #(.FIRST_COL(0)) uut2 (.sclk(clk), .rst_n(rst_n), .sdi(sdi), .load(load),
    .row_so(row_so2), .row_sclk(row_sclk2), .col_so(col_so2), .col_sclk(col_sclk2),
    .out_sel(out_sel2), .out_en(out_en2));

  logic [29:0] l_row, l_col, l_row2, l_col2;
  int n_row, n_col, n_row2, n_col2;
  frame_mon m_row (.clk(clk), .so(row_so), .last(l_row), .n(n_row));
  frame_mon m_col (.clk(clk), .so(col_so), .last(l_col), .n(n_col));
  frame_mon m_row2 (.clk(clk), .so(row_so2), .last(l_row2), .n(n_row2));
  frame_mon m_col2 (.clk(clk), .so(col_so2), .last(l_col2), .n(n_col2));

  task automatic chk(input bit ok, input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  function automatic logic [29:0] mk(input logic rd, input logic [5:0] r, input logic [5:0] c,
                                     input logic [15:0] cfg, input logic rep);
    return {rd, r, c, cfg, rep};
  endfunction

  function automatic logic [15:0] outs(input logic [15:0] cfg);
    logic [11:0] s; logic [3:0] e;
    for (int i = 0; i < 4; i++) begin
      s[i*3 +: 3] = cfg[15-4*i -: 3];
      e[i]        = cfg[12-4*i];
    end
    return {s, e};
  endfunction

  task automatic send(input logic [29:0] w);
    @(negedge clk) sdi = 1'b1;
    for (int i = 29; i >= 0; i--) begin
      @(negedge clk) sdi = w[i];
    end
    @(posedge clk); #1;
    sdi = 1'b0;
    lat_row = row_so;
    lat_col = col_so;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_load(input int n);
    @(negedge clk) load = 1'b1;
    repeat (n) @(negedge clk);
    load = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: got %0d expected %0d", 1, 0);
    finish_run();
  end

  initial begin
    logic [15:0] a, b, c, cfg;
    int n0, n1, n2, n3;
    idle(3);
    chk({out_sel, out_en, row_so, col_so} == '0, "R1", {out_sel, out_en, row_so, col_so}, 0);
    rst_n = 1;
    idle(3);
    chk({out_sel, out_en, row_so, col_so} == '0, "R1", {out_sel, out_en, row_so, col_so}, 0);

    a = 16'b1011_0101_1110_0011;
    n0 = n_row; n1 = n_col;
    send(mk(0, 0, 0, a, 0));
    chk(!lat_row && !lat_col, "R11", {lat_row, lat_col}, 0);
    idle(35);
    chk({out_sel, out_en} == 16'h0, "R2", {out_sel, out_en}, 0);
    chk(n_row == n0 && n_col == n1, "R11", n_row + n_col, n0 + n1);
    pulse_load(1);
    chk({out_sel, out_en} == outs(a), "R4", {out_sel, out_en}, outs(a));

    for (int p = 0; p < 16; p++) begin
      cfg = (16'(p) * 16'h1111) ^ 16'hA5C3 ^ {12'h0, 4'(p)};
      send(mk(0, 0, 0, cfg, 0));
      idle(2);
      pulse_load(1);
      chk({out_sel, out_en} == outs(cfg), "R2", {out_sel, out_en}, outs(cfg));
    end

    b = 16'h7E81;
    pulse_load(1);
    cfg = {out_sel, out_en};
    send(mk(0, 0, 0, b, 0));
    idle(40);
    chk({out_sel, out_en} == cfg, "R3", {out_sel, out_en}, cfg);
    pulse_load(3);
    chk({out_sel, out_en} == outs(b), "R4", {out_sel, out_en}, outs(b));

    c = 16'h3CD5;
    @(negedge clk) load = 1'b1;
    send(mk(0, 0, 0, c, 0));
    chk({out_sel, out_en} == outs(b), "R4", {out_sel, out_en}, outs(b));
    @(posedge clk); #1;
    chk({out_sel, out_en} == outs(c), "R4", {out_sel, out_en}, outs(c));
    @(negedge clk) load = 1'b0;

    for (int r = 1; r < 64; r++) begin
      logic [5:0] cc; logic [15:0] cf;
      cc = 6'((r * 7) % 64);
      cf = 16'(r * 977);
      n0 = n_col; n1 = n_row;
      send(mk(0, 6'(r), cc, cf, 0));
      chk(lat_col && !lat_row, "R11", {lat_row, lat_col}, 1);
      idle(33);
      chk(n_col == n0 + 1 && l_col == mk(0, 6'(r - 1), cc, cf, 0), "R5", l_col, mk(0, 6'(r - 1), cc, cf, 0));
      chk(n_row == n1, "R5", n_row, n1);
    end
    chk(n_row2 == 0 && n_col2 == 0, "R7", n_row2 + n_col2, 0);
    pulse_load(1);
    chk({out_sel, out_en} == outs(c), "R10", {out_sel, out_en}, outs(c));

    for (int k = 1; k < 64; k++) begin
      logic [15:0] cf;
      cf = 16'(k * 4099);
      n0 = n_row; n1 = n_col; n2 = n_row2;
      send(mk(k[0], 0, 6'(k), cf, 0));
      chk(lat_row && !lat_col, "R11", {lat_row, lat_col}, 2);
      idle(33);
      chk(n_row == n0 + 1 && l_row == mk(k[0], 0, 6'(k - 1), cf, 0), "R6", l_row, mk(k[0], 0, 6'(k - 1), cf, 0));
      chk(n_col == n1, "R6", n_col, n1);
      chk(n_row2 == n2 + 1 && l_row2 == mk(k[0], 0, 6'(k - 1), cf, 0), "R6", l_row2, mk(k[0], 0, 6'(k - 1), cf, 0));
    end
    chk(n_col2 == 0 && col_sclk2 == 1'b0, "R7", n_col2, 0);

    n0 = n_row; n1 = n_col;
    send(mk(1, 0, 0, 16'hFFFF, 0));
    chk(lat_row && lat_col, "R11", {lat_row, lat_col}, 3);
    idle(33);
    chk(n_row == n0 + 1 && l_row == mk(1, 63, 63, c, 1), "R8", l_row, mk(1, 63, 63, c, 1));
    chk(n_col == n1 + 1 && l_col == mk(1, 63, 63, c, 1), "R8", l_col, mk(1, 63, 63, c, 1));
    chk({out_sel, out_en} == outs(c), "R8", {out_sel, out_en}, outs(c));
    pulse_load(1);
    chk({out_sel, out_en} == outs(c), "R10", {out_sel, out_en}, outs(c));

    for (int k = 0; k < 8; k++) begin
      logic [5:0] rr, cc; logic [15:0] cf;
      rr = 6'(k * 9); cc = 6'(k * 8 + 1); cf = 16'(k * 8191 + 5);
      n0 = n_row; n1 = n_col; n2 = n_row2; n3 = n_col2;
      send(mk(1, rr, cc, cf, 1));
      idle(33);
      chk(n_row == n0 + 1 && l_row == mk(1, rr, cc - 6'd1, cf, 1), "R9", l_row, mk(1, rr, cc - 6'd1, cf, 1));
      chk(n_col == n1 && n_col2 == n3, "R9", n_col + n_col2, n1 + n3);
      chk(n_row2 == n2 + 1 && l_row2 == mk(1, rr, cc - 6'd1, cf, 1), "R9", l_row2, mk(1, rr, cc - 6'd1, cf, 1));
    end
    pulse_load(1);
    chk({out_sel, out_en} == outs(c), "R10", {out_sel, out_en}, outs(c));

    finish_run();
  end
endmodule